// File: doc/BRIEF.md
# Per-Pin Input Debounce Selector

This block cleans up the 32 input lines of one general-purpose I/O bank. Every line first passes through a two-stage synchronizer. A 2-bit selection code then decides how each line is filtered. Code 0 passes the synchronized level straight through. Codes 1, 2 and 3 each point at one of three shared, programmable hold counts. A line's filtered level follows a new raw level only once that level has been held for the chosen number of clock cycles.

The 2-bit code of a pin is split across two select words. The high bit sits in one word and the low bit in the other, each at the pin's own bit position. Software changes one pin's code by reading both words, changing the single bit and writing the words back. The register port is a plain word-indexed write strobe with a combinational read-back. There is no ownership gating, so any requester may write it.

Top module: `gpio_debounce_sel`

## Requirements
- R1: After reset, both select words and all three hold-count words read back as zero, so every pin starts unfiltered.
- R2: Word 0 holds the high bit of each pin's code and word 1 holds the low bit, both at bit position equal to the pin index. A write to either word loads it whole, and it reads back unchanged.
- R3: Words 2, 3 and 4 hold the hold counts used by codes 1, 2 and 3 and read back as written. Words 5 to 7 read as zero, and writes to them change no register.
- R4: A pin with code 0 shows a raw level change on its filtered output 2 clock edges after the change is sampled, which is the synchronizer delay and nothing more.
- R5: A pin with code 1 to 3 and hold count N of at least 1 shows a raw level change 2+N edges after the change is sampled, provided the raw level stays put throughout.
- R6: If the synchronized level returns to the filtered level before the hold count is reached, the pin's count restarts. A later change then needs the full hold count again.
- R7: A hold count of 0 acts like a count of 1.
- R8: Each pin has its own counter and code. Changing one pin's code by read-modify-write leaves every other pin's select bits and filtered output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_addr | input | 3 | Word index (0 select-high, 1 select-low, 2..4 hold counts) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read-back of the addressed word |
| pin_raw | input | 32 | Asynchronous raw input levels |
| pin_filt | output | 32 | Filtered input levels |

## Verification
Configuration writes take effect at the clock edge that samples the strobe. Read-back is combinational, so register checks sample shortly after the address is driven. A raw change driven just after cycle c reaches the filtered output in cycle c+2 for a bypassed pin and in cycle c+2+N for a filtered pin. The driver queues one item for the cycle just before each transition and one for the cycle of the transition, and the monitor compares the whole output word only in the cycle an item is due. The bounce case queues the point where an unreset count would already have fired, which checks the restart timing.

// File: rtl/gpio_dbsel_pkg.sv
package gpio_dbsel_pkg;
    localparam int CODE_W     = 2;
    localparam int NUM_TIMERS = (1 << CODE_W) - 1;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_SEL_HI   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEL_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_RLD_BASE = 3'd2;
endpackage

// File: rtl/gpio_dbsel_regs.sv
module gpio_dbsel_regs
    import gpio_dbsel_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [DATA_W-1:0]           cfg_rdata,
    output logic [NPINS-1:0]            sel_hi,
    output logic [NPINS-1:0]            sel_lo,
    output logic [NUM_TIMERS*CNT_W-1:0] reload_all
);
    typedef struct packed {
        logic [NPINS-1:0]                  hi;
        logic [NPINS-1:0]                  lo;
        logic [NUM_TIMERS-1:0][CNT_W-1:0]  rld;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_addr == ADDR_SEL_HI) cfg_d.hi = cfg_wdata[NPINS-1:0];
            if (cfg_addr == ADDR_SEL_LO) cfg_d.lo = cfg_wdata[NPINS-1:0];
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (cfg_addr == ADDR_RLD_BASE + ADDR_W'(t))
                    cfg_d.rld[t] = cfg_wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_SEL_HI) cfg_rdata[NPINS-1:0] = cfg_q.hi;
        if (cfg_addr == ADDR_SEL_LO) cfg_rdata[NPINS-1:0] = cfg_q.lo;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (cfg_addr == ADDR_RLD_BASE + ADDR_W'(t))
                cfg_rdata[CNT_W-1:0] = cfg_q.rld[t];
        end
    end

    assign sel_hi     = cfg_q.hi;
    assign sel_lo     = cfg_q.lo;
    assign reload_all = cfg_q.rld;

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && cfg_addr == ADDR_SEL_HI) |-> sel_hi == $past(cfg_wdata[NPINS-1:0]));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr < ADDR_RLD_BASE + ADDR_W'(NUM_TIMERS)) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_dbsel_sync.sv
module gpio_dbsel_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);
    typedef struct packed {
        logic [STAGES-1:0][NPINS-1:0] stg;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        sy_d.stg[0] = raw;
        for (int s = 1; s < STAGES; s++) sy_d.stg[s] = sy_q.stg[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign synced = sy_q.stg[STAGES-1];
endmodule

// File: rtl/gpio_dbsel_pin.sv
module gpio_dbsel_pin
    import gpio_dbsel_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_in,
    input  logic [CODE_W-1:0]           code,
    input  logic [NUM_TIMERS*CNT_W-1:0] reload_all,
    output logic                        filt
);
    typedef struct packed {
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } pin_t;

    pin_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   need;
    logic [CNT_W:0]   next_cnt;

    always_comb begin
        limit = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (code == CODE_W'(t + 1)) limit = reload_all[t*CNT_W +: CNT_W];
        end
        need     = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
        next_cnt = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
    end

    always_comb begin
        st_d = st_q;
        if (code == '0) begin
            st_d.stable = sync_in;
            st_d.cnt    = '0;
        end else if (sync_in == st_q.stable) begin
            st_d.cnt = '0;
        end else if (next_cnt >= need) begin
            st_d.stable = sync_in;
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = next_cnt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = (code == '0) ? sync_in : st_q.stable;

    // R5
    filt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stable != $past(st_q.stable)) |-> (st_q.stable == $past(sync_in)));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_in) == $past(st_q.stable)) |-> (st_q.cnt == '0));

    // R4
    bypass_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == '0) |-> (st_q.stable == $past(sync_in) && st_q.cnt == '0));
endmodule

// File: rtl/gpio_debounce_sel.sv
module gpio_debounce_sel
    import gpio_dbsel_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [NPINS-1:0]  pin_raw,
    output logic [NPINS-1:0]  pin_filt
);
    localparam int RLD_BITS = NUM_TIMERS * CNT_W;

    logic [NPINS-1:0]    sel_hi;
    logic [NPINS-1:0]    sel_lo;
    logic [RLD_BITS-1:0] reload_all;
    logic [NPINS-1:0]    synced;

    gpio_dbsel_regs #(.NPINS(NPINS), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .sel_hi     (sel_hi),
        .sel_lo     (sel_lo),
        .reload_all (reload_all)
    );

    gpio_dbsel_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_raw),
        .synced (synced)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_dbsel_pin #(.CNT_W(CNT_W)) u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_in    (synced[g]),
            .code       ({sel_hi[g], sel_lo[g]}),
            .reload_all (reload_all),
            .filt       (pin_filt[g])
        );
    end
endmodule

// File: tb/gpio_debounce_sel_test.sv
module gpio_debounce_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] pin_raw = '0;
    logic [31:0] pin_filt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int          due_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_debounce_sel uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    // monitor: compares pin_filt with each queued item in its due cycle
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] <= cyc) begin
            int d;
            logic [31:0] e;
            string t;
            d = due_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (pin_filt !== e) begin
                bad++;
                $display("FAIL %s: cycle %0d pin_filt=%h expected %h", t, d, pin_filt, e);
            end
        end
    end

    task automatic expect_at(int due, logic [31:0] v, string t);
        due_q.push_back(due);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic drain();
        while (due_q.size() > 0) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic chk_reg(logic [2:0] a, logic [31:0] e, string t);
        logic [31:0] d;
        rd(a, d);
        total++;
        if (d !== e) begin
            bad++;
            $display("FAIL %s: word %0d read %h expected %h", t, a, d, e);
        end
    endtask

    task automatic rmw(logic [2:0] a, logic [31:0] setm, logic [31:0] clrm);
        logic [31:0] d;
        rd(a, d);
        @(negedge clk);
        wr(a, (d & ~clrm) | setm);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) chk_reg(3'(a), 32'h0, "R1 reset word");

        // R4 bypass at reset
        @(negedge clk);
        c = cyc; pin_raw = 32'hA5A5_0F0F;
        expect_at(c + 1, 32'h0, "R4 bypass before");
        expect_at(c + 2, 32'hA5A5_0F0F, "R4 bypass after");
        drain();
        c = cyc; pin_raw = 32'h0;
        expect_at(c + 2, 32'h0, "R4 bypass back to zero");
        drain();

        // R3 hold counts
        @(negedge clk);
        wr(3'd2, 32'd4); wr(3'd3, 32'd7); wr(3'd4, 32'd1);
        chk_reg(3'd2, 32'd4, "R3 count word 2");
        chk_reg(3'd3, 32'd7, "R3 count word 3");
        chk_reg(3'd4, 32'd1, "R3 count word 4");
        chk_reg(3'd5, 32'd0, "R3 unmapped read");

        // R2 codes via read-modify-write: pin0=1 pin1=2 pin2=3
        @(negedge clk);
        rmw(3'd1, 32'h1, 32'h0);
        rmw(3'd0, 32'h2, 32'h0);
        rmw(3'd0, 32'h4, 32'h0);
        rmw(3'd1, 32'h4, 32'h0);
        chk_reg(3'd0, 32'h6, "R2 select-high");
        chk_reg(3'd1, 32'h5, "R2 select-low");
        // R8 pin5 code 1 keeps other bits
        @(negedge clk);
        rmw(3'd1, 32'h20, 32'h0);
        chk_reg(3'd1, 32'h25, "R8 select-low preserved");
        chk_reg(3'd0, 32'h6, "R8 select-high untouched");

        // R5 three hold counts at once
        @(negedge clk);
        c = cyc; pin_raw = 32'h7;
        expect_at(c + 2, 32'h0, "R5 none yet");
        expect_at(c + 3, 32'h4, "R5 pin2 count 1");
        expect_at(c + 5, 32'h4, "R5 pin0 holding");
        expect_at(c + 6, 32'h5, "R5 pin0 count 4");
        expect_at(c + 8, 32'h5, "R5 pin1 holding");
        expect_at(c + 9, 32'h7, "R5 pin1 count 7");
        drain();

        // R6 bounce on pin0 restarts its count
        @(negedge clk);
        c = cyc;
        expect_at(c + 7, 32'h7, "R6 no early change");
        expect_at(c + 9, 32'h7, "R6 count restarted");
        expect_at(c + 10, 32'h6, "R6 full count reached");
        pin_raw = 32'h6;
        repeat (2) @(negedge clk);
        pin_raw = 32'h7;
        repeat (2) @(negedge clk);
        pin_raw = 32'h6;
        drain();

        // R7 hold count zero
        @(negedge clk);
        wr(3'd4, 32'd0);
        chk_reg(3'd4, 32'd0, "R7 count word 4 zero");
        @(negedge clk);
        c = cyc; pin_raw = 32'h2;
        expect_at(c + 2, 32'h6, "R7 before");
        expect_at(c + 3, 32'h2, "R7 one-cycle hold");
        drain();

        // R8 switch pin1 to bypass, others untouched
        @(negedge clk);
        rmw(3'd0, 32'h0, 32'h2);
        chk_reg(3'd0, 32'h4, "R8 select-high after clear");
        chk_reg(3'd1, 32'h25, "R8 select-low after clear");
        @(negedge clk);
        c = cyc; pin_raw = 32'h0;
        expect_at(c + 1, 32'h2, "R8 pin1 before");
        expect_at(c + 2, 32'h0, "R8 pin1 bypass");
        drain();

        // R3 unmapped write has no effect
        @(negedge clk);
        wr(3'd6, 32'hFFFF_FFFF);
        chk_reg(3'd6, 32'h0, "R3 unmapped after write");
        chk_reg(3'd0, 32'h4, "R3 select-high unchanged");
        chk_reg(3'd2, 32'd4, "R3 count word 2 unchanged");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule